// File: doc/BRIEF.md
# Blocking Binary Semaphore with Wake Queue

This block is a hardware lock that a thread claims by writing its ID as a request and then reading back the owner value. A thread that asks while another thread holds the lock does not have to spin. Its ID is parked in a bounded first-in first-out wait list inside the block. When the owner gives the lock up by writing its own ID as a release, the oldest waiting thread becomes the owner at once. The same clock edge emits that thread's ID on one of two ready-queue write ports, so a scheduler can resume it.

The most significant bit of a thread ID classifies the thread. A processor thread has that bit at 0 and a hardware thread has it at 1. A hand-off to a processor thread also raises a one-cycle interrupt pulse. If the wait list is full, a further denied request is dropped and a sticky overflow flag is set. A release from any thread other than the owner changes nothing. A repeated request from the owner is not queued. The number of ID bits and the wait-list depth are parameters.

Top module: `wait_lock_sem`

## Requirements
- R1: A request written while the lock is free makes the requester the owner at the next rising clock edge, with owner_valid at 1 and owner_id equal to the requester's ID.
- R2: A request from a thread other than the owner, written while the lock is held, is stored in the wait list at the next edge. Waiting threads later receive the lock strictly in the order their requests arrived.
- R3: A release whose ID equals the owner's, written while the wait list is empty, frees the lock at the next edge. owner_valid goes to 0, owner_id reads 0, and neither ready port is written.
- R4: A release whose ID equals the owner's, written while threads are waiting, makes the oldest waiting thread the owner at the next edge. In that same cycle its ID is written to a ready port.
- R5: A woken ID whose most significant bit is 0 is written on the processor port (cpu_rdy_valid, cpu_rdy_id). One whose most significant bit is 1 is written on the hardware port (hw_rdy_valid, hw_rdy_id). At most one port is written per cycle.
- R6: cpu_irq is high for exactly the cycles in which the processor port is written. A single hand-off gives a single one-cycle pulse.
- R7: A request that would be queued while the wait list already holds DEPTH entries, and no entry leaves in that cycle, is discarded. overflow then goes to 1 and stays there until reset.
- R8: A release carrying an ID other than the current owner's, or arriving while the lock is free, leaves the owner, the wait list and the ready ports unchanged.
- R9: A request from the current owner is not added to the wait list.
- R10: When a request and a release arrive in the same cycle, the release is applied first. The request is then judged against the state that results from the release.
- R11: After reset the lock is free, owner_id is 0, overflow is 0 and neither ready port nor cpu_irq is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request write strobe |
| req_id | input | ID_W | ID of the requesting thread |
| rel_valid | input | 1 | Release write strobe |
| rel_id | input | ID_W | ID of the releasing thread |
| owner_valid | output | 1 | Lock is held |
| owner_id | output | ID_W | Current owner, 0 while free |
| cpu_rdy_valid | output | 1 | Write strobe of the processor ready queue |
| cpu_rdy_id | output | ID_W | ID written to the processor ready queue |
| hw_rdy_valid | output | 1 | Write strobe of the hardware ready queue |
| hw_rdy_id | output | ID_W | ID written to the hardware ready queue |
| cpu_irq | output | 1 | One-cycle interrupt on a processor hand-off |
| overflow | output | 1 | Sticky: a request was lost to a full wait list |

## Verification
The bench builds the block with ID_W = 3 and DEPTH = 2. With those values all eight IDs, four per ready port, and a full wait list can each be reached within a few requests. Every cycle is compared with an arithmetic reference model in the bench. Directed sequences cover hand-off order, port routing, the overflow drop, foreign releases, owner re-requests and same-cycle request and release. A long pseudo-random run then drives the request, release and ID inputs and visits every combination of lock state, queue fill and release outcome many times.

// File: rtl/wlsem_pkg.sv
package wlsem_pkg;

   // classification of an incoming request after the release is applied
   typedef enum logic [1:0] {
      REQ_IDLE  = 2'd0,
      REQ_GRANT = 2'd1,
      REQ_OWNER = 2'd2,
      REQ_WAIT  = 2'd3
   } req_kind_e;

   // per-cycle decision bundle produced by the decision logic
   typedef struct packed {
      logic rel_ok;
      logic pop;
      logic push;
      logic drop;
      logic nxt_locked;
   } sem_step_t;

endpackage

// File: rtl/wlsem_fifo.sv
module wlsem_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CW-1:0] cnt;

   generate
      if (DEPTH == 1) begin : g_single
         assign rd_nxt = '0;
         assign wr_nxt = '0;
      end else if (POW2) begin : g_pow2
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);                                     // R4
   AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));                            // R7

endmodule

// File: rtl/wlsem_decide.sv
module wlsem_decide
   import wlsem_pkg::*;
#(
   parameter int ID_W = 8
) (
   input  logic            locked,
   input  logic [ID_W-1:0] owner,
   input  logic            req_valid,
   input  logic [ID_W-1:0] req_id,
   input  logic            rel_valid,
   input  logic [ID_W-1:0] rel_id,
   input  logic            q_empty,
   input  logic            q_full,
   input  logic [ID_W-1:0] q_head,
   output sem_step_t       step,
   output logic [ID_W-1:0] nxt_owner
);

   logic            rel_ok, pop, mid_locked;
   logic [ID_W-1:0] mid_owner;
   req_kind_e       kind;

   // release stage: only the owner may release
   assign rel_ok     = rel_valid && locked && (rel_id == owner);
   assign pop        = rel_ok && !q_empty;
   assign mid_locked = locked && !(rel_ok && q_empty);
   assign mid_owner  = pop ? q_head : owner;

   // request stage judged against the post-release state
   always_comb begin
      if (!req_valid)              kind = REQ_IDLE;
      else if (!mid_locked)        kind = REQ_GRANT;
      else if (req_id == mid_owner) kind = REQ_OWNER;
      else                         kind = REQ_WAIT;
   end

   always_comb begin
      step.rel_ok     = rel_ok;
      step.pop        = pop;
      step.push       = (kind == REQ_WAIT) && (!q_full || pop);
      step.drop       = (kind == REQ_WAIT) && q_full && !pop;
      step.nxt_locked = mid_locked || (kind == REQ_GRANT);
      if (kind == REQ_GRANT)  nxt_owner = req_id;
      else if (mid_locked)    nxt_owner = mid_owner;
      else                    nxt_owner = '0;
   end

endmodule

// File: rtl/wlsem_route.sv
module wlsem_route #(
   parameter int ID_W   = 8,
   parameter bit HW_MSB = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [ID_W-1:0] id,
   output logic            cpu_v,
   output logic [ID_W-1:0] cpu_id,
   output logic            hw_v,
   output logic [ID_W-1:0] hw_id,
   output logic            irq
);

   logic to_hw;
   assign to_hw = (id[ID_W-1] == HW_MSB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_v  <= 1'b0;
         hw_v   <= 1'b0;
         irq    <= 1'b0;
         cpu_id <= '0;
         hw_id  <= '0;
      end else begin
         cpu_v <= fire && !to_hw;
         hw_v  <= fire && to_hw;
         irq   <= fire && !to_hw;
         if (fire && !to_hw) cpu_id <= id;
         if (fire && to_hw)  hw_id  <= id;
      end
   end

   AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_v, hw_v}));                            // R5
   AST_CPU_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_v |-> (cpu_id[ID_W-1] != HW_MSB));               // R5
   AST_HW_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      hw_v |-> (hw_id[ID_W-1] == HW_MSB));                 // R5

endmodule

// File: rtl/wait_lock_sem.sv
module wait_lock_sem
   import wlsem_pkg::*;
#(
   parameter int ID_W   = 8,
   parameter int DEPTH  = 8,
   parameter bit HW_MSB = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [ID_W-1:0] req_id,
   input  logic            rel_valid,
   input  logic [ID_W-1:0] rel_id,
   output logic            owner_valid,
   output logic [ID_W-1:0] owner_id,
   output logic            cpu_rdy_valid,
   output logic [ID_W-1:0] cpu_rdy_id,
   output logic            hw_rdy_valid,
   output logic [ID_W-1:0] hw_rdy_id,
   output logic            cpu_irq,
   output logic            overflow
);

   generate
      if (ID_W < 2) begin : g_bad_idw
         $error("wait_lock_sem: ID_W must be at least 2");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("wait_lock_sem: DEPTH must be at least 1");
      end
   endgenerate

   logic            locked_q, ovf_q;
   logic [ID_W-1:0] owner_q, nxt_owner, q_head;
   logic            q_empty, q_full;
   sem_step_t       step;

   wlsem_decide #(.ID_W(ID_W)) u_decide (
      .locked    (locked_q),
      .owner     (owner_q),
      .req_valid (req_valid),
      .req_id    (req_id),
      .rel_valid (rel_valid),
      .rel_id    (rel_id),
      .q_empty   (q_empty),
      .q_full    (q_full),
      .q_head    (q_head),
      .step      (step),
      .nxt_owner (nxt_owner)
   );

   wlsem_fifo #(.W(ID_W), .DEPTH(DEPTH)) u_waitq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (step.push),
      .din   (req_id),
      .pop   (step.pop),
      .head  (q_head),
      .empty (q_empty),
      .full  (q_full)
   );

   wlsem_route #(.ID_W(ID_W), .HW_MSB(HW_MSB)) u_route (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (step.pop),
      .id     (q_head),
      .cpu_v  (cpu_rdy_valid),
      .cpu_id (cpu_rdy_id),
      .hw_v   (hw_rdy_valid),
      .hw_id  (hw_rdy_id),
      .irq    (cpu_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         owner_q  <= '0;
         ovf_q    <= 1'b0;
      end else begin
         locked_q <= step.nxt_locked;
         owner_q  <= nxt_owner;
         if (step.drop) ovf_q <= 1'b1;
      end
   end

   assign owner_valid = locked_q;
   assign owner_id    = owner_q;
   assign overflow    = ovf_q;

   AST_FREE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (!owner_valid && req_valid) |=> (owner_valid && owner_id == $past(req_id))); // R1
   AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_valid && rel_valid && rel_id == owner_id && q_empty && !req_valid)
      |=> (!owner_valid && !cpu_rdy_valid && !hw_rdy_valid));                     // R3
   AST_HANDOFF_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdy_valid || hw_rdy_valid) |->
      (owner_valid && owner_id == (cpu_rdy_valid ? cpu_rdy_id : hw_rdy_id)));      // R4
   AST_FOREIGN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_valid && rel_valid && rel_id != owner_id && !req_valid)
      |=> (owner_valid && $stable(owner_id)));                                     // R8
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);                                                      // R7
   AST_IRQ_WITH_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> cpu_rdy_valid);                                                  // R6

endmodule

// File: tb/wait_lock_sem_tb.sv
`timescale 1ns/1ps
module wait_lock_sem_tb;

   localparam int ID_W  = 3;
   localparam int DEPTH = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0, rel_valid = 1'b0;
   logic [ID_W-1:0] req_id = '0, rel_id = '0;
   logic            owner_valid, cpu_rdy_valid, hw_rdy_valid, cpu_irq, overflow;
   logic [ID_W-1:0] owner_id, cpu_rdy_id, hw_rdy_id;

   int checks = 0;
   int fails  = 0;

   // reference model state
   bit m_lk, m_ovf, e_cpu, e_hw;
   int m_own, e_cpu_id, e_hw_id;
   int mq[$];

   always #2 clk = ~clk;

   wait_lock_sem #(.ID_W(ID_W), .DEPTH(DEPTH)) u_dut (
      .clk, .rst_n, .req_valid, .req_id, .rel_valid, .rel_id,
      .owner_valid, .owner_id, .cpu_rdy_valid, .cpu_rdy_id,
      .hw_rdy_valid, .hw_rdy_id, .cpu_irq, .overflow
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_lk = 0; m_ovf = 0; e_cpu = 0; e_hw = 0;
      m_own = 0; e_cpu_id = 0; e_hw_id = 0;
      mq.delete();
   endtask

   task automatic model_clock(input bit rv, input int rid, input bit lv, input int lid);
      bit rel_ok, pop, mlk;
      int mown, head;
      rel_ok = lv && m_lk && (lid == m_own);
      pop    = rel_ok && (mq.size() > 0);
      head   = pop ? mq[0] : 0;
      mlk    = m_lk && !(rel_ok && mq.size() == 0);
      mown   = pop ? head : m_own;
      if (pop) void'(mq.pop_front());
      e_cpu = pop && (head < 4);
      e_hw  = pop && (head >= 4);
      if (e_cpu) e_cpu_id = head;
      if (e_hw)  e_hw_id  = head;
      if (rv) begin
         if (!mlk) begin
            mlk = 1; mown = rid;
         end else if (rid != mown) begin
            if (mq.size() < DEPTH) mq.push_back(rid);
            else m_ovf = 1;
         end
      end
      m_lk  = mlk;
      m_own = mlk ? mown : 0;
   endtask

   task automatic step(input bit rv, input int rid, input bit lv, input int lid);
      @(negedge clk);
      req_valid = rv; req_id = rid[ID_W-1:0];
      rel_valid = lv; rel_id = lid[ID_W-1:0];
      @(posedge clk);
      model_clock(rv, rid, lv, lid);
      #1;
      chk("R1 owner_valid", int'(owner_valid), int'(m_lk));
      chk("R1 owner_id", int'(owner_id), m_own);
      chk("R5 cpu_rdy_valid", int'(cpu_rdy_valid), int'(e_cpu));
      chk("R5 hw_rdy_valid", int'(hw_rdy_valid), int'(e_hw));
      if (e_cpu) chk("R5 cpu_rdy_id", int'(cpu_rdy_id), e_cpu_id);
      if (e_hw)  chk("R5 hw_rdy_id", int'(hw_rdy_id), e_hw_id);
      chk("R6 cpu_irq", int'(cpu_irq), int'(e_cpu));
      chk("R7 overflow", int'(overflow), int'(m_ovf));
   endtask

   task automatic do_reset();
      @(negedge clk);
      req_valid = 0; rel_valid = 0; rst_n = 0;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R11 owner_valid", int'(owner_valid), 0);
      chk("R11 owner_id", int'(owner_id), 0);
      chk("R11 overflow", int'(overflow), 0);
      chk("R11 ready ports", int'(cpu_rdy_valid | hw_rdy_valid | cpu_irq), 0);
   endtask

   initial begin : watchdog
      #(4 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      bit [15:0] lf;
      do_reset();

      // R1 grant on a free lock, R9 owner re-request not queued
      step(1, 1, 0, 0);
      chk("R1 first grant", int'(owner_id), 1);
      step(1, 1, 0, 0);
      step(0, 0, 1, 1);
      chk("R9 re-request left queue empty", int'(owner_valid), 0);
      chk("R3 free release no wake", int'(cpu_rdy_valid | hw_rdy_valid), 0);

      // R2 queueing and R7 overflow with DEPTH 2
      step(1, 2, 0, 0);
      step(1, 5, 0, 0);
      step(1, 3, 0, 0);
      chk("R7 not yet overflowed", int'(overflow), 0);
      step(1, 6, 0, 0);
      chk("R7 overflow set", int'(overflow), 1);

      // R8 foreign release ignored
      step(0, 0, 1, 7);
      chk("R8 owner kept", int'(owner_id), 2);
      chk("R8 no wake", int'(cpu_rdy_valid | hw_rdy_valid), 0);

      // R4 hand-off to hardware thread 5, then processor thread 3
      step(0, 0, 1, 2);
      chk("R4 new owner", int'(owner_id), 5);
      chk("R2 oldest first", int'(hw_rdy_id), 5);
      chk("R5 hw port", int'(hw_rdy_valid), 1);
      step(0, 0, 1, 5);
      chk("R2 second waiter", int'(owner_id), 3);
      chk("R6 irq raised", int'(cpu_irq), 1);
      step(0, 0, 0, 0);
      chk("R6 irq one cycle", int'(cpu_irq), 0);
      step(0, 0, 1, 3);
      chk("R3 freed, dropped id absent", int'(owner_valid), 0);
      chk("R7 still sticky", int'(overflow), 1);

      // R10 simultaneous request and release
      step(1, 4, 0, 0);
      step(1, 1, 0, 0);
      step(1, 2, 1, 4);
      chk("R10 hand-off first", int'(owner_id), 1);
      chk("R10 wake id", int'(cpu_rdy_id), 1);
      step(0, 0, 1, 1);
      chk("R10 request queued behind", int'(owner_id), 2);
      step(1, 0, 1, 2);
      chk("R10 free then grant", int'(owner_valid), 1);
      chk("R10 new owner", int'(owner_id), 0);
      step(0, 0, 1, 0);

      // pseudo-random sweep against the model
      do_reset();
      lf = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
         bit rv, lv;
         int rid, lid;
         lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         rv  = lf[0] & (lf[1] | lf[2]);
         rid = int'(lf[5:3]);
         lv  = lf[6] & lf[7];
         lid = lf[8] ? m_own : int'(lf[11:9]);
         if (i == 3000) do_reset();
         step(rv, rid, lv, lid);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule